// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is one parallel I/O port of a microcontroller. Each pin has a direction bit and an output data bit. Software sets these through a small bus with a chip select, a one-bit register address, write and read strobes and a data byte. The block drives an output-enable and an output value for every pad. It also samples the pad levels through a synchronizer, so that a port read can return the live state of the input pins.

A port read returns a different source per bit. A pin set as an output reads back the latched data bit, whatever level the pad actually shows. A pin set as an input reads back its synchronized pad level. The direction register cannot be read: a read of its address returns a fixed filler pattern.

The block has two low-power inputs that act differently. Hardware standby wipes both registers and wins over everything else in the same cycle. Software standby freezes both registers: bus writes are dropped while it is high, and the pads keep being driven from the held values.

Top module: `gpio_port`

## Requirements
- R1: After the asynchronous reset (rst_n low), the direction and data registers are all zeros, so pin_oe and pin_out are 0x00.
- R2: A write with cs=1, wr=1 and addr=1 (direction register) loads wdata, and pin_oe equals that value after the clock edge that takes the write. A direction bit of 1 enables the pin driver.
- R3: A write with cs=1, wr=1 and addr=0 (data register) loads wdata, and pin_out equals that value after the clock edge that takes the write.
- R4: A read with cs=1, rd=1 and addr=1 returns the fixed pattern DIR_READ_VALUE (default 0xFF) on rdata, whatever the register holds.
- R5: A read with cs=1, rd=1 and addr=0 returns, for each bit whose direction bit is 1, the data register bit, independent of pin_in.
- R6: On the same data read, each bit whose direction bit is 0 returns the synchronized level of that pin_in bit.
- R7: On every clock edge where hw_stby is 1, both registers are cleared to zero. This holds even when sw_stby is 1 or a write is presented in the same cycle.
- R8: While sw_stby is 1 and hw_stby is 0, writes to either register are ignored, and pin_oe and pin_out keep their previous values.
- R9: When cs or rd is 0, rdata is 0x00.
- R10: A change on an input pin appears on rdata after exactly two rising clock edges (SYNC_STAGES, default 2), and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby, clears both registers |
| sw_stby | input | 1 | Software standby, freezes both registers |
| cs | input | 1 | Port select |
| addr | input | 1 | Register select: 0 data, 1 direction |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, combinational |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_oe | output | WIDTH | Per-pin driver enable |
| pin_out | output | WIDTH | Per-pin driven value |

## Verification
Data reads are tried with the direction at all ones, all zeros and a split nibble. The pads are driven to patterns that differ from the latched data. An all-output read that shows the pad would expose a mux using the wrong source, and the split case catches a mux that uses the wrong select polarity or bit order. The pads are toggled one edge at a time to tell a one-stage synchronizer from a two-stage one. Standby is tried with writes offered in the same cycle, and with both standby inputs high together, to separate freezing from clearing and to confirm which standby wins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // Register select carried on the one-bit address
   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_DIR  = 1'b1
   } gpio_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] d;
      if (s == 0) begin : g_first
         assign d = async_i;
      end else begin : g_next
         assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= d;
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic             dir_we,
   input  logic             dat_we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] dat_q
);

   // Hardware standby clears ahead of any write enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         dat_q <= '0;
      end else if (hw_stby) begin
         dir_q <= '0;
         dat_q <= '0;
      end else begin
         if (dir_we) dir_q <= wdata;
         if (dat_we) dat_q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
   parameter int               WIDTH          = 8,
   parameter logic [WIDTH-1:0] DIR_READ_VALUE = '1
) (
   input  logic             rd_en,
   input  logic             sel_dir,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] dat_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] port_val;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign port_val[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
   end

   always_comb begin
      if (!rd_en)       rdata = '0;
      else if (sel_dir) rdata = DIR_READ_VALUE;
      else              rdata = port_val;
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int               WIDTH          = 8,
   parameter int               SYNC_STAGES    = 2,
   parameter logic [WIDTH-1:0] DIR_READ_VALUE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             cs,
   input  logic             addr,
   input  logic             wr,
   input  logic             rd,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_port: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   gpio_sel_e        sel;
   logic             wr_ok;
   logic             dir_we;
   logic             dat_we;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] dat_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel    = gpio_sel_e'(addr);
   assign wr_ok  = cs & wr & ~sw_stby;
   assign dir_we = wr_ok & (sel == SEL_DIR);
   assign dat_we = wr_ok & (sel == SEL_DATA);

   gpio_regbank #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_stby (hw_stby),
      .dir_we  (dir_we),
      .dat_we  (dat_we),
      .wdata   (wdata),
      .dir_q   (dir_q),
      .dat_q   (dat_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );

   gpio_rdmux #(.WIDTH(WIDTH), .DIR_READ_VALUE(DIR_READ_VALUE)) u_rdmux (
      .rd_en    (cs & rd),
      .sel_dir  (sel == SEL_DIR),
      .dir_q    (dir_q),
      .dat_q    (dat_q),
      .pin_sync (pin_sync),
      .rdata    (rdata)
   );

   assign pin_oe  = dir_q;
   assign pin_out = dat_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int               WIDTH          = 8,
   parameter logic [WIDTH-1:0] DIR_READ_VALUE = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_stby,
   input logic             sw_stby,
   input logic             cs,
   input logic             addr,
   input logic             wr,
   input logic             rd,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] rdata,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_out
);

   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr && !sw_stby && !hw_stby) |=> (pin_oe == $past(wdata)));

   // R3
   dat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && !addr && !sw_stby && !hw_stby) |=> (pin_out == $past(wdata)));

   // R4
   dir_filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && addr) |-> (rdata == DIR_READ_VALUE));

   // R5
   out_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && rd && !addr) |-> (((rdata ^ pin_out) & pin_oe) == '0));

   // R7
   hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (pin_oe == '0 && pin_out == '0));

   // R8
   sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && !hw_stby) |=> ($stable(pin_oe) && $stable(pin_out)));

   // R9
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && rd) |-> (rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH          (WIDTH),
   .DIR_READ_VALUE (DIR_READ_VALUE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hw_stby (hw_stby),
   .sw_stby (sw_stby),
   .cs      (cs),
   .addr    (addr),
   .wr      (wr),
   .rd      (rd),
   .wdata   (wdata),
   .rdata   (rdata),
   .pin_oe  (pin_oe),
   .pin_out (pin_out)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby = 1'b0;
   logic       sw_stby = 1'b0;
   logic       cs = 1'b0;
   logic       addr = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe;
   logic [7:0] pin_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   gpio_port u_gpio_port (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .cs(cs), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Drive at negedge, captured at posedge, back at the next negedge
   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1 d = rdata;
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      chk("R1 pin_oe after reset", pin_oe, 8'h00);
      chk("R1 pin_out after reset", pin_out, 8'h00);
      bus_read(1'b1, v);
      chk("R4 direction read filler", v, 8'hFF);
   endtask

   task automatic t_idle();
      @(negedge clk);
      cs = 1'b0; rd = 1'b1; addr = 1'b1;
      #1 chk("R9 rd without cs", rdata, 8'h00);
      cs = 1'b1; rd = 1'b0;
      #1 chk("R9 cs without rd", rdata, 8'h00);
      cs = 1'b0;
   endtask

   task automatic t_writes();
      logic [7:0] v;
      bus_write(1'b1, 8'hA5);
      chk("R2 pin_oe after direction write", pin_oe, 8'hA5);
      bus_read(1'b1, v);
      chk("R4 direction read ignores content", v, 8'hFF);
      bus_write(1'b0, 8'h3C);
      chk("R3 pin_out after data write", pin_out, 8'h3C);
   endtask

   task automatic t_outputs_read();
      logic [7:0] v;
      bus_write(1'b1, 8'hFF);
      pin_in = 8'h00;
      settle();
      bus_read(1'b0, v);
      chk("R5 all outputs, pads low", v, 8'h3C);
      pin_in = 8'hFF;
      settle();
      bus_read(1'b0, v);
      chk("R5 all outputs, pads high", v, 8'h3C);
   endtask

   task automatic t_inputs_read();
      logic [7:0] v;
      bus_write(1'b1, 8'h00);
      pin_in = 8'h5A;
      settle();
      bus_read(1'b0, v);
      chk("R6 all inputs", v, 8'h5A);
      bus_write(1'b1, 8'hF0);
      settle();
      bus_read(1'b0, v);
      chk("R5 R6 split direction", v, 8'h3A);
   endtask

   task automatic t_latency();
      logic [7:0] v;
      bus_write(1'b1, 8'h00);
      pin_in = 8'h00;
      settle();
      @(negedge clk);
      pin_in = 8'hFF;
      @(posedge clk);
      bus_read(1'b0, v);
      chk("R10 one edge, old level", v, 8'h00);
      bus_read(1'b0, v);
      chk("R10 two edges, new level", v, 8'hFF);
   endtask

   task automatic t_sw_stby();
      bus_write(1'b1, 8'h0F);
      bus_write(1'b0, 8'h55);
      @(negedge clk);
      sw_stby = 1'b1;
      bus_write(1'b1, 8'hFF);
      bus_write(1'b0, 8'h00);
      chk("R8 direction kept in sw standby", pin_oe, 8'h0F);
      chk("R8 data kept in sw standby", pin_out, 8'h55);
      @(negedge clk);
      sw_stby = 1'b0;
      @(negedge clk);
      chk("R8 direction after sw standby exit", pin_oe, 8'h0F);
      bus_write(1'b0, 8'h99);
      chk("R3 write after sw standby exit", pin_out, 8'h99);
   endtask

   task automatic t_hw_stby();
      bus_write(1'b1, 8'hC3);
      @(negedge clk);
      hw_stby = 1'b1; sw_stby = 1'b1;
      cs = 1'b1; wr = 1'b1; addr = 1'b1; wdata = 8'hAA;
      @(posedge clk);
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
      chk("R7 direction cleared over sw standby and write", pin_oe, 8'h00);
      chk("R7 data cleared", pin_out, 8'h00);
      sw_stby = 1'b0;
      bus_write(1'b0, 8'h77);
      chk("R7 write blocked during hw standby", pin_out, 8'h00);
      @(negedge clk);
      hw_stby = 1'b0;
      bus_write(1'b0, 8'h77);
      chk("R3 write after hw standby exit", pin_out, 8'h77);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_writes();
      t_outputs_read();
      t_inputs_read();
      t_latency();
      t_sw_stby();
      t_hw_stby();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule